// File: doc/BRIEF.md
# Pin Falling-Edge Interrupt and Wake Controller

This block watches seven general-purpose pins and reports every high-to-low transition seen on a pin that is currently configured as an input. Each pin owns one sticky event flag. Hardware sets the flag when a falling edge arrives, and software reads the flag register to find which pin caused the event, then clears it by writing zeros. A single global enable bit decides whether pending flags raise an interrupt request. The request stays asserted until software clears the flags or drops the enable.

Independent of that enable, every qualified falling edge produces a one-cycle wake pulse for a core that is halted or stopped. The core therefore resumes on any edge, and it takes the interrupt first only when the enable is set. Pins pass through a two-flop synchronizer before edge detection, so the block accepts asynchronous pad levels. A small register bus with address, write data, write strobe and combinational read data gives access to the control and flag registers.

Top module: `pin_fall_irq`

## Requirements
- R1: After reset, the flag register and the enable bit are 0, and `irq_o` and `wake_o` are low.
- R2: A falling edge on input-mode pin n sets flag bit n of the flag register at address 0x02. It is readable there on the third rising clock edge after the pin changes.
- R3: A rising edge, a steady level, or a pin that is already low when reset is released sets no flag and produces no wake pulse.
- R4: A falling edge on a pin whose `pin_is_input_i` bit is 0 sets no flag and produces no wake pulse.
- R5: Each qualified falling edge gives `wake_o` high for exactly one cycle, at the same time as the flag appears. This happens whether the enable bit is 0 or 1.
- R6: The enable is bit 2 of the control register at address 0x00. That bit reads back as written, and the other control bits read 0.
- R7: `irq_o` is high exactly when the enable is 1 and at least one flag is set. It stays high until the flags are cleared or the enable is cleared.
- R8: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. Bit 7 of the flag register always reads 0, and flags never drop without a write to it.
- R9: If a hardware set and a software clear reach the same flag on the same clock edge, the flag ends up set.
- R10: Reads from any address other than 0x00 and 0x02 return 0, and writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 7 | Raw pin levels, bit n is pin n |
| pin_is_input_i | input | 7 | Per-pin input-mode qualifier, 1 means input |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_we_i | input | 1 | Write strobe, one clock per write |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request, level |
| wake_o | output | 1 | Wake pulse, one cycle per falling edge |

## Verification
A pin change takes three rising edges to become visible: two synchronizer stages, then the edge comparison that loads the flag and the wake register. The bench therefore drives pins on a falling clock edge and samples flags, `wake_o` and `irq_o` on the third falling edge after that. Register writes take effect on the rising edge that samples the strobe, and reads are combinational, so the checks read back at the next falling edge. The set-versus-clear case aligns the write strobe with that third rising edge, so that the hardware set and the software clear meet on the same edge.

// File: rtl/pfi_pkg.sv
`timescale 1ns/1ps
package pfi_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_FLAG = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(
        input logic [15:0] addr,
        input logic [15:0] ctrl_addr,
        input logic [15:0] flag_addr
    );
        if (addr == ctrl_addr)      return SEL_CTRL;
        else if (addr == flag_addr) return SEL_FLAG;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/pfi_sync.sv
`timescale 1ns/1ps
module pfi_sync #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] stage1;
        logic [N-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = raw_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage2;
endmodule

// File: rtl/pfi_fall_detect.sv
`timescale 1ns/1ps
module pfi_fall_detect #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] qual_i,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // per-pin edge: previously high, now low, and pin in input mode
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign fall_o[i] = st_q.prev[i] & ~level_i[i] & qual_i[i];
    end
endmodule

// File: rtl/pfi_regs.sv
`timescale 1ns/1ps
module pfi_regs
    import pfi_pkg::*;
#(
    parameter int                N         = 7,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h02,
    parameter int                EN_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      fall_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      flags_o,
    output logic              en_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int AW16 = 16;

    typedef struct packed {
        logic [N-1:0] flags;
        logic         en;
        logic         wake;
    } regs_t;

    regs_t        st_d, st_q;
    reg_sel_e     sel;
    logic [N-1:0] keep_mask;

    always_comb begin
        sel = decode_addr(AW16'(addr_i), AW16'(CTRL_ADDR), AW16'(FLAG_ADDR));

        keep_mask = '1;
        if (we_i && sel == SEL_FLAG) keep_mask = wdata_i[N-1:0];

        st_d       = st_q;
        // hardware set is ORed after the software clear: set wins
        st_d.flags = (st_q.flags & keep_mask) | fall_i;
        if (we_i && sel == SEL_CTRL) st_d.en = wdata_i[EN_BIT];
        st_d.wake  = |fall_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_CTRL: rdata_o[EN_BIT] = st_q.en;
            SEL_FLAG: rdata_o = DATA_W'(st_q.flags);
            default:  rdata_o = '0;
        endcase
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;
    assign irq_o   = st_q.en & (|st_q.flags);
    assign wake_o  = st_q.wake;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/pin_fall_irq.sv
`timescale 1ns/1ps
module pin_fall_irq #(
    parameter int                N_PINS    = 7,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h02,
    parameter int                EN_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] pin_is_input_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] fall_w;
    logic [N_PINS-1:0] flags_w;
    logic              en_w;

    pfi_sync #(.N(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .sync_o (pin_sync)
    );

    pfi_fall_detect #(.N(N_PINS)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_sync),
        .qual_i  (pin_is_input_i),
        .fall_o  (fall_w)
    );

    pfi_regs #(
        .N         (N_PINS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .FLAG_ADDR (FLAG_ADDR),
        .EN_BIT    (EN_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall_w),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .we_i    (bus_we_i),
        .rdata_o (bus_rdata_o),
        .flags_o (flags_w),
        .en_o    (en_w),
        .irq_o   (irq_o),
        .wake_o  (wake_o)
    );
endmodule

// File: rtl/pfi_checker.sv
`timescale 1ns/1ps
module pfi_checker #(
    parameter int                N         = 7,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h02,
    parameter int                EN_BIT    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      fall,
    input logic [N-1:0]      flags,
    input logic              en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              we,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              wake
);
    AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((flags & $past(fall)) == $past(fall)));            // R9
    AST_FLAG_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(fall)) == '0));                // R3
    AST_WAKE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> wake);                                              // R5
    AST_WAKE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|fall) |=> !wake);                                            // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == FLAG_ADDR) |=> ((flags & $past(flags)) == $past(flags))); // R8
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !we) |=> irq);                                          // R7
    AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == FLAG_ADDR) |-> (rdata[DATA_W-1] == 1'b0));             // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != FLAG_ADDR && addr != CTRL_ADDR) |-> (rdata == '0));    // R10
    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CTRL_ADDR) |=> (en == $past(wdata[EN_BIT])));    // R6
endmodule

bind pin_fall_irq pfi_checker #(
    .N         (N_PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .FLAG_ADDR (FLAG_ADDR),
    .EN_BIT    (EN_BIT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .fall  (fall_w),
    .flags (flags_w),
    .en    (en_w),
    .addr  (bus_addr_i),
    .wdata (bus_wdata_i),
    .we    (bus_we_i),
    .rdata (bus_rdata_o),
    .irq   (irq_o),
    .wake  (wake_o)
);

// File: tb/pin_fall_irq_tb.sv
`timescale 1ns/1ps
module pin_fall_irq_tb;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_FLAG = 8'h02;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pin_i = 7'h00;
    logic [6:0] pin_is_input_i = 7'h7F;
    logic [7:0] bus_addr_i = A_FLAG;
    logic [7:0] bus_wdata_i = 8'h00;
    logic       bus_we_i = 1'b0;
    logic [7:0] bus_rdata_o;
    logic       irq_o;
    logic       wake_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pin_fall_irq u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_i          (pin_i),
        .pin_is_input_i (pin_is_input_i),
        .bus_addr_i     (bus_addr_i),
        .bus_wdata_i    (bus_wdata_i),
        .bus_we_i       (bus_we_i),
        .bus_rdata_o    (bus_rdata_o),
        .irq_o          (irq_o),
        .wake_o         (wake_o)
    );

    // {pins, expected flags, expected wake}; enable stays 0 during the walk
    localparam logic [14:0] VEC [0:5] = '{
        {7'h7F, 7'h00, 1'b0},   // rising edges only
        {7'h7E, 7'h01, 1'b1},   // pin 0 falls
        {7'h7E, 7'h01, 1'b0},   // steady level
        {7'h3C, 7'h43, 1'b1},   // pins 6 and 1 fall
        {7'h7F, 7'h43, 1'b0},   // rising again
        {7'h00, 7'h7F, 1'b1}    // all fall
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr_i = a;
        #0.5;
        v = bus_rdata_o;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    // drive on a falling edge, return on the third falling edge after it
    task automatic drive_pins(input logic [6:0] p);
        @(negedge clk);
        pin_i = p;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rd(A_FLAG, v); check("R1 flags in reset", v, 8'h00);
        check("R1 irq in reset", {7'h0, irq_o}, 8'h00);
        check("R1 wake in reset", {7'h0, wake_o}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_CTRL, v); check("R1 enable after reset", v, 8'h00);
        rd(A_FLAG, v); check("R3 low pin at reset release", v, 8'h00);
        check("R3 no wake at release", {7'h0, wake_o}, 8'h00);

        foreach (VEC[i]) begin
            drive_pins(VEC[i][14:8]);
            check("R5 wake vector", {7'h0, wake_o}, {7'h0, VEC[i][0]});
            check("R7 irq gated off", {7'h0, irq_o}, 8'h00);
            rd(A_FLAG, v); check("R2 R3 flags vector", v, {1'b0, VEC[i][7:1]});
        end

        wr(A_FLAG, 8'h00);
        rd(A_FLAG, v); check("R8 clear all", v, 8'h00);
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, v); check("R6 enable readback", v, 8'h04);
        check("R7 no irq without flags", {7'h0, irq_o}, 8'h00);

        drive_pins(7'h7F);
        rd(A_FLAG, v); check("R3 rise with enable", v, 8'h00);
        drive_pins(7'h77);
        check("R5 wake enabled", {7'h0, wake_o}, 8'h01);
        check("R7 irq raised", {7'h0, irq_o}, 8'h01);
        rd(A_FLAG, v); check("R2 pin 3 flag", v, 8'h08);

        wr(A_FLAG, 8'hFF);
        rd(A_FLAG, v); check("R8 write ones keeps, bit7 zero", v, 8'h08);
        check("R7 irq held", {7'h0, irq_o}, 8'h01);

        wr(8'h01, 8'h00);
        rd(8'h01, v); check("R10 unmapped read", v, 8'h00);
        rd(A_FLAG, v); check("R10 flags untouched", v, 8'h08);
        rd(A_CTRL, v); check("R10 ctrl untouched", v, 8'h04);

        wr(A_CTRL, 8'h00);
        check("R7 irq drops with enable", {7'h0, irq_o}, 8'h00);
        drive_pins(7'h73);
        check("R5 wake with enable off", {7'h0, wake_o}, 8'h01);
        check("R7 irq stays off", {7'h0, irq_o}, 8'h00);
        rd(A_FLAG, v); check("R2 pin 2 flag", v, 8'h0C);

        pin_is_input_i = 7'h6F;
        drive_pins(7'h63);
        check("R4 no wake non-input", {7'h0, wake_o}, 8'h00);
        rd(A_FLAG, v); check("R4 no flag non-input", v, 8'h0C);
        pin_is_input_i = 7'h7F;

        wr(A_FLAG, 8'h7B);
        rd(A_FLAG, v); check("R8 clear one bit", v, 8'h08);

        // set-versus-clear on the same edge
        @(negedge clk);
        pin_i = 7'h62;
        @(negedge clk);
        @(negedge clk);
        bus_addr_i = A_FLAG; bus_wdata_i = 8'h00; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0;
        rd(A_FLAG, v); check("R9 set wins over clear", v, 8'h01);

        rst_n = 1'b0;
        @(negedge clk);
        rd(A_FLAG, v); check("R1 flags after second reset", v, 8'h00);
        rd(A_CTRL, v); check("R1 enable after second reset", v, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule